// File: doc/BRIEF.md
# Byte-Lane Controller for an Asynchronous Nonvolatile SRAM-Style Memory

This block sits between a synchronous host and an external asynchronous 16-bit memory. That memory has an 18-bit word address, active-low select, write-strobe and read-drive pins, and one active-low select per byte lane. The host issues one read or one write at a time on a valid/ready port. Each request carries a word address, write data and a per-byte mask. The controller turns the request into a pin sequence. All pins are registered, so they change together on one clock edge. Every phase length is a whole number of clock cycles, derived at elaboration from the clock period and the memory's nanosecond limits. Read data comes back on a one-cycle response strobe.

Writes are strobe-controlled. The chip select and the byte selects fall first, one cycle before the write strobe. The write strobe is then pulsed, and the read-drive pin stays high for the whole write, so the memory never drives the bus during a write. After reset the controller refuses all requests for a power-up wait and holds every control pin high. The bidirectional data bus is modelled as separate output, output-enable and input vectors.

A request with an empty byte mask completes without selecting the memory.

Top module: `mctl_async_sram`

## Requirements
- R1: After reset release, `req_ready` stays low and `mem_ce_n`, `mem_we_n`, `mem_oe_n` and all of `mem_be_n` stay high for exactly PWR_CYC = max(1, ceil(POWERUP_NS / CLK_NS)) cycles. `mem_dq_oe` stays low during that time. `req_ready` rises after that time.
- R2: A read with a non-empty mask drives `mem_ce_n`, `mem_oe_n` and the selected byte selects low together for RD_CYC cycles, with `mem_we_n` high. RD_CYC is the larger of the rounded-up cycle time and the rounded-up access time. `rsp_valid` is high for one cycle, RD_CYC cycles after the acceptance edge. It carries the data sampled in the last cycle of that window.
- R3: Mask bit 0 selects the lower lane (data bits 7:0, `mem_be_n[0]`). Mask bit 1 selects the upper lane (bits 15:8, `mem_be_n[1]`). A write changes only the selected lanes. A read returns zero in the unselected lanes.
- R4: A write holds one setup cycle with `mem_ce_n` low and `mem_we_n` high. `mem_we_n` is then low for WP_CYC = max(ceil(T_WP), ceil(T_AVWH) - 1, ceil(T_DS) - 1, 1) cycles. `mem_oe_n` stays high throughout, and `mem_we_n` is never low while `mem_ce_n` is high.
- R5: After the write strobe rises, all control pins go high. The address holds, and no new request is accepted for WREC_CYC = max(ceil(T_WR), ceil(T_HIGH), ceil(T_CYCLE) - 1 - WP_CYC) cycles.
- R6: `mem_dq_oe` is high from the setup cycle through the first cycle after `mem_we_n` rises, and low otherwise. It is never high while `mem_oe_n` is low, and it is low in the cycle before `mem_oe_n` falls.
- R7: A request with mask 00 never lowers `mem_ce_n`. For a read, `rsp_valid` with data 0 appears in the cycle after the acceptance edge. `req_ready` stays high.
- R8: After a read window, all control pins are high for HI_CYC = max(1, ceil(T_HIGH)) cycles before `req_ready` returns.
- R9: A request is accepted only on a clock edge with `req_valid` and `req_ready` both high. Each accepted request with a non-empty mask produces exactly one `mem_ce_n` low period. `req_ready` is low whenever `mem_ce_n` is low.
- R10: `mem_addr` does not change while `mem_ce_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lane mask, bit 0 lower lane |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 18 | Memory address pins |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Read drive enable, active low |
| mem_be_n | output | 2 | Byte lane selects, active low, bit 0 lower |
| mem_dq_out | output | 16 | Data driven to memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_in | input | 16 | Data returned by memory |

## Verification
With an 8 ns clock and the default limits, the read response is due 5 cycles after the acceptance edge and `req_ready` returns one cycle later. A write frees the port 5 cycles after acceptance and holds the write strobe low for 2 cycles. The power-up wait lasts 250 cycles for a 2000 ns setting, and an empty-mask read answers in the cycle right after acceptance. The bench drives on falling edges and counts falling edges from acceptance, so each latency is compared against the exact expected count rather than a window. A behavioural memory model samples the pins at the same falling edges to confirm lane contents, strobe widths and bus ownership.

// File: rtl/mctl_pkg.sv
package mctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_GAP,
      ST_WSET,
      ST_WPUL,
      ST_WREC
   } mctl_state_e;

   // nanoseconds to clock cycles, rounded up, never below one cycle
   function automatic int cyc_of(input int ns, input int clk_ns);
      int c;
      c = (ns + clk_ns - 1) / clk_ns;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/mctl_pwrup.sv
module mctl_pwrup #(
   parameter int WAIT_CYC = 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic done
);
   localparam int W = $clog2(WAIT_CYC + 1);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         done  <= 1'b0;
      end else if (!done) begin
         if (cnt_q == W'(WAIT_CYC - 1)) done <= 1'b1;
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/mctl_lanes.sv
module mctl_lanes #(
   parameter int LANES  = 2,
   parameter int LANE_W = 8
) (
   input  logic [LANES-1:0]        sel_n,
   input  logic [LANES*LANE_W-1:0] raw,
   output logic [LANES*LANE_W-1:0] merged
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign merged[i*LANE_W +: LANE_W] = sel_n[i] ? '0 : raw[i*LANE_W +: LANE_W];
   end
endmodule

// File: rtl/mctl_async_sram.sv
module mctl_async_sram
   import mctl_pkg::*;
#(
   parameter int ADDR_W      = 18,
   parameter int DATA_W      = 16,
   parameter int CLK_NS      = 8,
   parameter int T_CYCLE_NS  = 35,
   parameter int T_ACCESS_NS = 35,
   parameter int T_WP_NS     = 15,
   parameter int T_AVWH_NS   = 18,
   parameter int T_DS_NS     = 10,
   parameter int T_WR_NS     = 12,
   parameter int T_HIGH_NS   = 2,
   parameter int POWERUP_NS  = 2000000,
   localparam int LANES      = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_mask,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [LANES-1:0]  mem_be_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);
   localparam int CYC_MIN  = cyc_of(T_CYCLE_NS, CLK_NS);
   localparam int RD_CYC   = imax(CYC_MIN, cyc_of(T_ACCESS_NS, CLK_NS));
   localparam int WP_CYC   = imax(imax(cyc_of(T_WP_NS, CLK_NS), cyc_of(T_AVWH_NS, CLK_NS) - 1),
                                  imax(cyc_of(T_DS_NS, CLK_NS) - 1, 1));
   localparam int HI_CYC   = cyc_of(T_HIGH_NS, CLK_NS);
   localparam int WREC_CYC = imax(imax(cyc_of(T_WR_NS, CLK_NS), HI_CYC), CYC_MIN - 1 - WP_CYC);
   localparam int PWR_CYC  = cyc_of(POWERUP_NS, CLK_NS);
   localparam int CNT_MAX  = imax(imax(RD_CYC, WP_CYC), imax(WREC_CYC, HI_CYC));
   localparam int CNT_W    = $clog2(CNT_MAX + 1);

   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("DATA_W must be a positive multiple of 8");
   end
   if (CLK_NS < 1) begin : g_bad_clk
      $error("CLK_NS must be at least 1");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end

   mctl_state_e       state;
   logic [CNT_W-1:0]  cnt;
   logic              pwr_done;
   logic              ce_n_q, we_n_q, oe_n_q, doe_q, rsp_v_q;
   logic [LANES-1:0]  be_n_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] dout_q, rdata_q, rd_merged;

   mctl_pwrup #(.WAIT_CYC(PWR_CYC)) u_pwrup (
      .clk   (clk),
      .rst_n (rst_n),
      .done  (pwr_done)
   );

   mctl_lanes #(.LANES(LANES), .LANE_W(8)) u_lanes (
      .sel_n  (be_n_q),
      .raw    (mem_dq_in),
      .merged (rd_merged)
   );

   assign req_ready  = pwr_done && (state == ST_IDLE);
   assign rsp_valid  = rsp_v_q;
   assign rsp_rdata  = rdata_q;
   assign mem_addr   = addr_q;
   assign mem_ce_n   = ce_n_q;
   assign mem_we_n   = we_n_q;
   assign mem_oe_n   = oe_n_q;
   assign mem_be_n   = be_n_q;
   assign mem_dq_out = dout_q;
   assign mem_dq_oe  = doe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         ce_n_q  <= 1'b1;
         we_n_q  <= 1'b1;
         oe_n_q  <= 1'b1;
         be_n_q  <= '1;
         addr_q  <= '0;
         dout_q  <= '0;
         doe_q   <= 1'b0;
         rsp_v_q <= 1'b0;
         rdata_q <= '0;
      end else begin
         rsp_v_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req_valid && req_ready) begin
                  addr_q <= req_addr;
                  if (req_mask == '0) begin
                     if (!req_write) begin
                        rsp_v_q <= 1'b1;
                        rdata_q <= '0;
                     end
                  end else if (req_write) begin
                     ce_n_q <= 1'b0;
                     be_n_q <= ~req_mask;
                     dout_q <= req_wdata;
                     doe_q  <= 1'b1;
                     state  <= ST_WSET;
                  end else begin
                     ce_n_q <= 1'b0;
                     oe_n_q <= 1'b0;
                     be_n_q <= ~req_mask;
                     cnt    <= CNT_W'(RD_CYC - 1);
                     state  <= ST_RD;
                  end
               end
            end
            ST_RD: begin
               if (cnt == '0) begin
                  rdata_q <= rd_merged;
                  rsp_v_q <= 1'b1;
                  ce_n_q  <= 1'b1;
                  oe_n_q  <= 1'b1;
                  be_n_q  <= '1;
                  cnt     <= CNT_W'(HI_CYC - 1);
                  state   <= ST_GAP;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_GAP: begin
               if (cnt == '0) state <= ST_IDLE;
               else           cnt   <= cnt - 1'b1;
            end
            ST_WSET: begin
               we_n_q <= 1'b0;
               cnt    <= CNT_W'(WP_CYC - 1);
               state  <= ST_WPUL;
            end
            ST_WPUL: begin
               if (cnt == '0) begin
                  we_n_q <= 1'b1;
                  ce_n_q <= 1'b1;
                  be_n_q <= '1;
                  cnt    <= CNT_W'(WREC_CYC - 1);
                  state  <= ST_WREC;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_WREC: begin
               doe_q <= 1'b0;
               if (cnt == '0) state <= ST_IDLE;
               else           cnt   <= cnt - 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mctl_async_sram_chk.sv
module mctl_async_sram_chk #(
   parameter int ADDR_W = 18,
   parameter int LANES  = 2,
   parameter int WP_MIN = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pwr_done,
   input logic              req_ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ce_n,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic [LANES-1:0]  mem_be_n,
   input logic              mem_dq_oe
);
   logic [7:0] wlow_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         wlow_q <= '0;
      else if (!mem_we_n) wlow_q <= (wlow_q == 8'hFF) ? wlow_q : wlow_q + 8'd1;
      else                wlow_q <= '0;
   end

   AST_PWRUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_done |-> (mem_ce_n && mem_we_n && mem_oe_n && (&mem_be_n) && !mem_dq_oe && !req_ready)); // R1
   AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> !mem_ce_n); // R4
   AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_oe_n); // R4
   AST_WE_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (int'(wlow_q) >= WP_MIN)); // R4
   AST_BUS_DRIVEN_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_dq_oe); // R6
   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_dq_oe); // R6
   AST_GAP_BEFORE_OE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_oe_n) |-> !$past(mem_dq_oe)); // R6
   AST_LANES_IDLE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ce_n |-> (&mem_be_n)); // R8
   AST_BUSY_WHILE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |-> !req_ready); // R9
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R10
endmodule

bind mctl_async_sram mctl_async_sram_chk #(
   .ADDR_W (ADDR_W),
   .LANES  (LANES),
   .WP_MIN (WP_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pwr_done  (pwr_done),
   .req_ready (req_ready),
   .mem_addr  (mem_addr),
   .mem_ce_n  (mem_ce_n),
   .mem_we_n  (mem_we_n),
   .mem_oe_n  (mem_oe_n),
   .mem_be_n  (mem_be_n),
   .mem_dq_oe (mem_dq_oe)
);

// File: tb/mctl_async_sram_tb_top.sv
`timescale 1ns/1ps
module mctl_async_sram_tb_top;
   localparam int CLKP = 8;
   localparam int PWR_NS = 2000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic        req_ready, rsp_valid;
   logic [17:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_mask = '0;
   logic [15:0] rsp_rdata;
   logic [17:0] mem_addr;
   logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [1:0]  mem_be_n;
   logic [15:0] mem_dq_out, mem_dq_in;

   int checks = 0, failures = 0;
   bit done_flag = 0;

   always #4 clk = ~clk;

   mctl_async_sram #(.POWERUP_NS(PWR_NS), .CLK_NS(CLKP)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   function automatic int cdiv(input int ns);
      int c;
      c = (ns + CLKP - 1) / CLKP;
      return (c < 1) ? 1 : c;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int E_RD   = 5;   // max(ceil(35/8), ceil(35/8))
   localparam int E_WP   = 2;   // max(ceil(15/8), ceil(18/8)-1, ceil(10/8)-1, 1)
   localparam int E_WREC = 2;   // max(ceil(12/8), ceil(2/8), 5-1-2)
   localparam int E_HI   = 1;
   localparam int E_PWR  = 250;

   function automatic int idx(input logic [17:0] a);
      return int'({a[17:15], a[2:0]});
   endfunction

   // behavioural memory and bench reference
   logic [15:0] mem_m [0:63];
   logic [15:0] ref_m [0:63];

   assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? mem_m[idx(mem_addr)] : 16'hA5A5;

   // pin monitors, sampled on falling edges
   int ce_run = 0, we_run = 0, last_ce_w = 0, last_we_w = 0, setup_w = 0;
   int ce_falls = 0, contention = 0, bad_oe = 0, addr_moves = 0;
   logic        prev_ce_n = 1'b1;
   logic [17:0] prev_addr = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!mem_ce_n && !mem_we_n) begin
            for (int l = 0; l < 2; l++)
               if (!mem_be_n[l])
                  mem_m[idx(mem_addr)][l*8 +: 8] <= mem_dq_oe ? mem_dq_out[l*8 +: 8] : 8'hDE;
         end
         if (mem_dq_oe && !mem_oe_n) contention++;
         if (!mem_we_n && !mem_oe_n) bad_oe++;
         if (!mem_ce_n && prev_ce_n) ce_falls++;
         if (!mem_ce_n && !prev_ce_n && mem_addr != prev_addr) addr_moves++;
         if (!mem_ce_n) ce_run++;
         else if (ce_run > 0) begin last_ce_w = ce_run; ce_run = 0; end
         if (!mem_we_n) begin
            if (we_run == 0) setup_w = ce_run - 1;
            we_run++;
         end else if (we_run > 0) begin last_we_w = we_run; we_run = 0; end
         prev_ce_n = mem_ce_n;
         prev_addr = mem_addr;
      end
   end

   task automatic chk(input string tag, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic finish_tb();
      if (!done_flag) begin
         done_flag = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   task automatic do_req(input bit wr, input logic [17:0] a, input logic [15:0] d,
                         input logic [1:0] m, output int rsp_lat, output int rdy_lat,
                         output logic [15:0] rd);
      int n;
      @(negedge clk);
      req_write = wr; req_addr = a; req_wdata = d; req_mask = m; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      rsp_lat = -1; rd = '0; n = 0;
      forever begin
         if (rsp_valid && rsp_lat < 0) begin rsp_lat = n; rd = rsp_rdata; end
         if (req_ready || n > 100) break;
         @(negedge clk);
         n++;
      end
      rdy_lat = n;
      if (wr) begin
         for (int l = 0; l < 2; l++)
            if (m[l]) ref_m[idx(a)][l*8 +: 8] = d[l*8 +: 8];
      end
   endtask

   function automatic logic [15:0] exp_rd(input logic [17:0] a, input logic [1:0] m);
      logic [15:0] v;
      v = ref_m[idx(a)];
      return {m[1] ? v[15:8] : 8'h00, m[0] ? v[7:0] : 8'h00};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_tb();
   end

   initial begin
      int rl, yl, n, pins_bad, cf;
      logic [15:0] rd;
      logic [17:0] a;
      void'($urandom(32'h1F2E3D4C));
      for (int i = 0; i < 64; i++) begin
         mem_m[i] = 16'(i * 16'h0101) ^ 16'h3C5A;
         ref_m[i] = 16'(i * 16'h0101) ^ 16'h3C5A;
      end
      repeat (4) @(negedge clk);
      // R1 reset state
      chk("R1", int'(req_ready), 0, "ready in reset");
      chk("R1", int'({mem_ce_n, mem_we_n, mem_oe_n, mem_be_n}), 5'h1F, "pins in reset");
      chk("R1", int'(mem_dq_oe), 0, "bus drive in reset");
      rst_n = 1'b1;
      n = 0; pins_bad = 0;
      while (!req_ready && n < 1000) begin
         @(negedge clk);
         n++;
         if (!({mem_ce_n, mem_we_n, mem_oe_n, mem_be_n} == 5'h1F) || mem_dq_oe) pins_bad++;
      end
      chk("R1", n, mx(E_PWR, cdiv(PWR_NS)), "power-up wait cycles");
      chk("R1", pins_bad, 0, "pins left idle during wait");

      a = 18'h2A005;
      do_req(1, a, 16'h1234, 2'b11, rl, yl, rd);
      chk("R4", last_we_w, E_WP, "write strobe width");
      chk("R4", setup_w, 1, "select-to-strobe setup cycles");
      chk("R5", yl, 1 + E_WP + E_WREC, "write occupancy");
      do_req(0, a, 16'h0, 2'b11, rl, yl, rd);
      chk("R2", rl, E_RD, "read response latency");
      chk("R2", last_ce_w, E_RD, "read select width");
      chk("R8", yl, E_RD + E_HI, "read occupancy");
      chk("R2", int'(rd), 16'h1234, "word read data");
      do_req(1, a, 16'hABCD, 2'b01, rl, yl, rd);
      do_req(0, a, 16'h0, 2'b11, rl, yl, rd);
      chk("R3", int'(rd), 16'h12CD, "lower-lane write");
      do_req(1, a, 16'hEF99, 2'b10, rl, yl, rd);
      do_req(0, a, 16'h0, 2'b11, rl, yl, rd);
      chk("R3", int'(rd), 16'hEFCD, "upper-lane write");
      do_req(0, a, 16'h0, 2'b01, rl, yl, rd);
      chk("R3", int'(rd), 16'h00CD, "lower-lane read zeroes upper");
      do_req(0, a, 16'h0, 2'b10, rl, yl, rd);
      chk("R3", int'(rd), 16'hEF00, "upper-lane read zeroes lower");
      cf = ce_falls;
      do_req(1, a, 16'h0000, 2'b00, rl, yl, rd);
      chk("R7", ce_falls - cf, 0, "empty-mask write selects memory");
      chk("R7", yl, 0, "empty-mask write ready");
      do_req(0, a, 16'h0, 2'b00, rl, yl, rd);
      chk("R7", rl, 0, "empty-mask read latency");
      chk("R7", int'(rd), 0, "empty-mask read data");
      chk("R7", ce_falls - cf, 0, "empty-mask read selects memory");
      do_req(0, a, 16'h0, 2'b11, rl, yl, rd);
      chk("R7", int'(rd), 16'hEFCD, "data after empty-mask write");

      for (int k = 0; k < 300; k++) begin
         bit wr;
         logic [1:0] m;
         logic [15:0] exp_v;
         wr = 1'($urandom);
         m = 2'($urandom);
         a = 18'($urandom);
         if (k % 5 == 0) a = {3'b111, 12'h000, 3'b000};
         exp_v = exp_rd(a, m);
         cf = ce_falls;
         do_req(wr, a, 16'($urandom), m, rl, yl, rd);
         chk("R9", ce_falls - cf, (m != 2'b00) ? 1 : 0, "select periods per request");
         if (!wr) begin
            chk("R3", int'(rd), int'(exp_v), "random read data");
            chk("R2", rl, (m == 2'b00) ? 0 : E_RD, "random read latency");
         end else if (m != 2'b00) begin
            chk("R5", yl, 1 + E_WP + E_WREC, "random write occupancy");
         end
      end

      chk("R6", contention, 0, "bus driven while memory drives");
      chk("R4", bad_oe, 0, "read drive low during write");
      chk("R10", addr_moves, 0, "address moved while selected");
      finish_tb();
   end
endmodule